// File: doc/BRIEF.md
# Cache-Block Zero and Maintenance Engine

This block takes one cache-block request at a time from a core's execute stage. A request is one of three kinds: zero, clean/flush, or invalidate. Before any memory traffic, the block checks whether the request may run. The inputs to that check are the current privilege level, the virtualization flag, and three per-level enable vectors (machine, hypervisor, supervisor), each holding one bit per request kind. A blocked request ends with an illegal-instruction or virtual-instruction cause.

A permitted zero request first rounds its address down to the block boundary. It then writes zero words across the whole block through a valid/ready write port, one word per accepted beat, in ascending address order. The write happens regardless of whether the target region is cacheable. An access fault reported on any accepted beat stops the block and returns a store-fault cause.

Clean/flush and invalidate requests move no data. They complete when the target block is readable or writable, as reported by two permission inputs that stand in for translation and protection. When neither is true, they end with a store fault.

Top module: `cbo_engine`

## Requirements
- R1: Request kinds are coded zero=0, clean/flush=1, invalidate=2; code 3 is reserved and always ends with the illegal-instruction cause (2). Each enable vector is indexed by the kind: bit 0 zero, bit 1 clean/flush, bit 2 invalidate.
- R2: Privilege is coded user=0, supervisor=1, machine=3. When privilege is not machine and the machine enable bit for the kind is clear, the request ends with illegal-instruction (cause 2), whatever the other inputs are.
- R3: Otherwise, when virtualization is on and either the hypervisor bit is clear at user or supervisor privilege, or the supervisor bit is clear at user privilege, the request ends with virtual-instruction (cause 22).
- R4: Otherwise, at user privilege with the supervisor bit clear, the request ends with illegal-instruction (cause 2).
- R5: At machine privilege, the enable vectors never block a request.
- R6: A permitted zero request issues BLOCK_BYTES/WORD_BYTES writes of all-zero data. The first write goes to the request address with its low log2(BLOCK_BYTES) bits cleared, and each later write is WORD_BYTES higher.
- R7: While a write is offered and not accepted, the address stays unchanged and the write stays offered.
- R8: `done` pulses for one cycle in the cycle after the last beat is accepted without a fault. No further writes follow.
- R9: An access fault on an accepted beat ends the request in the next cycle with the store-fault cause (7). No further writes and no `done` follow.
- R10: A permitted clean/flush or invalidate request issues no writes. It pulses `done` in the cycle after acceptance when it is readable or writable; otherwise it reports the store-fault cause (7).
- R11: A blocked request reports `exc_valid` with its cause in the cycle after acceptance, for one cycle. `exc_cause` reads 0 whenever `exc_valid` is low, and `req_ready` is low while a zero request is writing.
- R12: After reset, `req_ready` is high and `mem_wvalid`, `done` and `exc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| req_op | input | 2 | Request kind |
| req_addr | input | ADDR_W | Target address, any alignment |
| req_priv | input | 2 | Current privilege |
| req_virt | input | 1 | Virtualization active |
| menv_en | input | 3 | Machine-level enables, one per kind |
| henv_en | input | 3 | Hypervisor-level enables, one per kind |
| senv_en | input | 3 | Supervisor-level enables, one per kind |
| probe_rd_ok | input | 1 | Target block readable (maintenance kinds) |
| probe_wr_ok | input | 1 | Target block writable (maintenance kinds) |
| mem_wvalid | output | 1 | Write beat offered |
| mem_wready | input | 1 | Write beat accepted |
| mem_waddr | output | ADDR_W | Write beat address |
| mem_wdata | output | 8*WORD_BYTES | Write beat data, always zero |
| mem_fault | input | 1 | Access fault on the accepted beat |
| done | output | 1 | Request finished without exception |
| exc_valid | output | 1 | Request finished with exception |
| exc_cause | output | 5 | Exception cause code |

## Verification
Several properties are checked on every cycle:
- the priority of the machine-level check over the other two;
- that machine privilege is never blocked by an enable bit;
- that an offered write holds while stalled and steps by one word after each clean beat;
- alignment of each beat;
- the abort after a faulting beat;
- that `done` and `exc_valid` are never high together.

Some behaviour can only be shown by the bench's scenarios against its reference function. That includes the exact beat count and the first address of each zero request, the choice between virtual-instruction and the late illegal-instruction check, and the outcome of maintenance requests under each combination of the two permission inputs.

// File: rtl/cbo_pkg.sv
package cbo_pkg;

    typedef enum logic [1:0] {
        OP_ZERO  = 2'd0,
        OP_CLEAN = 2'd1,
        OP_INVAL = 2'd2,
        OP_RSVD  = 2'd3
    } cbo_op_e;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [4:0] {
        CAUSE_NONE        = 5'd0,
        CAUSE_ILLEGAL     = 5'd2,
        CAUSE_STORE_FAULT = 5'd7,
        CAUSE_VIRT        = 5'd22
    } cause_e;

    typedef struct packed {
        logic   fault;
        cause_e cause;
    } perm_res_t;

    // Pick the enable bit that belongs to a request kind.
    function automatic logic op_enable(input logic [2:0] en, input cbo_op_e op);
        case (op)
            OP_ZERO:  return en[0];
            OP_CLEAN: return en[1];
            OP_INVAL: return en[2];
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cbo_perm_gate.sv
module cbo_perm_gate
    import cbo_pkg::*;
(
    input  cbo_op_e    op,
    input  priv_e      priv,
    input  logic       virt,
    input  logic [2:0] m_en,
    input  logic [2:0] h_en,
    input  logic [2:0] s_en,
    output perm_res_t  res
);
    logic m_ok, h_ok, s_ok;

    always_comb begin
        m_ok = op_enable(m_en, op);
        h_ok = op_enable(h_en, op);
        s_ok = op_enable(s_en, op);
        res  = '{fault: 1'b0, cause: CAUSE_NONE};
        // Ordered tiers: the first hit decides the cause.
        if (op == OP_RSVD) begin
            res = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
        end else if (priv != PRV_MACH && !m_ok) begin
            res = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
        end else if (virt && ((priv <= PRV_SUPER && !h_ok) ||
                              (priv == PRV_USER && !s_ok))) begin
            res = '{fault: 1'b1, cause: CAUSE_VIRT};
        end else if (priv == PRV_USER && !s_ok) begin
            res = '{fault: 1'b1, cause: CAUSE_ILLEGAL};
        end
    end

endmodule

// File: rtl/cbo_zero_seq.sv
module cbo_zero_seq #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 64,
    parameter int WORD_BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              wvalid,
    input  logic              wready,
    input  logic              fault,
    output logic [ADDR_W-1:0] waddr,
    output logic              fin,
    output logic              abort
);
    localparam int BEATS   = BLOCK_BYTES / WORD_BYTES;
    localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int WORD_SH = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] BLK_MASK  = ~ADDR_W'(BLOCK_BYTES - 1);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] base;
    logic              last;
    logic              take;

    assign wvalid = busy;
    assign last   = (beat == LAST_BEAT);
    assign take   = busy && wready;
    assign fin    = take && !fault && last;
    assign abort  = take && fault;
    assign waddr  = base + (ADDR_W'(beat) << WORD_SH);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            beat <= '0;
            base <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            beat <= '0;
            base <= start_addr & BLK_MASK;
        end else if (take) begin
            if (fault || last) begin
                busy <= 1'b0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end

    // R6
    word_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        wvalid |-> ((waddr & ADDR_W'(WORD_BYTES - 1)) == '0));

    // R6
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !fault && !last) |=> (wvalid && waddr == $past(waddr) + ADDR_W'(WORD_BYTES)));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wvalid && !wready) |=> (wvalid && $stable(waddr)));

    // R8
    stop_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        fin |=> !wvalid);

endmodule

// File: rtl/cbo_engine.sv
module cbo_engine
    import cbo_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 64,
    parameter int WORD_BYTES  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_op,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_priv,
    input  logic                    req_virt,
    input  logic [2:0]              menv_en,
    input  logic [2:0]              henv_en,
    input  logic [2:0]              senv_en,
    input  logic                    probe_rd_ok,
    input  logic                    probe_wr_ok,
    output logic                    mem_wvalid,
    input  logic                    mem_wready,
    output logic [ADDR_W-1:0]       mem_waddr,
    output logic [8*WORD_BYTES-1:0] mem_wdata,
    input  logic                    mem_fault,
    output logic                    done,
    output logic                    exc_valid,
    output logic [4:0]              exc_cause
);
    cbo_op_e   op_in;
    priv_e     priv_in;
    perm_res_t perm;
    logic      accept, busy, start, seq_fin, seq_abort;
    logic      maint_ok, maint_bad;
    logic      done_d, exc_d;
    cause_e    cause_d, cause_q;

    assign op_in   = cbo_op_e'(req_op);
    assign priv_in = priv_e'(req_priv);

    cbo_perm_gate perm_i (
        .op   (op_in),
        .priv (priv_in),
        .virt (req_virt),
        .m_en (menv_en),
        .h_en (henv_en),
        .s_en (senv_en),
        .res  (perm)
    );

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign start     = accept && !perm.fault && op_in == OP_ZERO;
    assign maint_ok  = accept && !perm.fault && op_in != OP_ZERO && (probe_rd_ok || probe_wr_ok);
    assign maint_bad = accept && !perm.fault && op_in != OP_ZERO && !(probe_rd_ok || probe_wr_ok);

    cbo_zero_seq #(
        .ADDR_W      (ADDR_W),
        .BLOCK_BYTES (BLOCK_BYTES),
        .WORD_BYTES  (WORD_BYTES)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (req_addr),
        .busy       (busy),
        .wvalid     (mem_wvalid),
        .wready     (mem_wready),
        .fault      (mem_fault),
        .waddr      (mem_waddr),
        .fin        (seq_fin),
        .abort      (seq_abort)
    );

    assign mem_wdata = '0;

    always_comb begin
        done_d  = seq_fin || maint_ok;
        exc_d   = (accept && perm.fault) || maint_bad || seq_abort;
        cause_d = CAUSE_NONE;
        if (accept && perm.fault) begin
            cause_d = perm.cause;
        end else if (maint_bad || seq_abort) begin
            cause_d = CAUSE_STORE_FAULT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            exc_valid <= 1'b0;
            cause_q   <= CAUSE_NONE;
        end else begin
            done      <= done_d;
            exc_valid <= exc_d;
            cause_q   <= cause_d;
        end
    end

    assign exc_cause = cause_q;

    // R2
    mach_tier_first_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && req_priv != 2'd3 && req_op != 2'd3 && !op_enable(menv_en, op_in))
        |=> (exc_valid && exc_cause == 5'd2));

    // R5
    mach_never_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && req_priv == 2'd3 && req_op != 2'd3)
        |=> !(exc_valid && exc_cause != 5'd7));

    // R9
    fault_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wvalid && mem_wready && mem_fault)
        |=> (!mem_wvalid && exc_valid && exc_cause == 5'd7 && !done));

    // R11
    single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && exc_valid));

    // R11
    quiet_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |-> exc_cause == 5'd0);

    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wvalid |-> !req_ready);

    // R12
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !mem_wvalid && !done && !exc_valid));

endmodule

// File: tb/cbo_engine_tb.sv
module cbo_engine_tb_top;
    localparam int ADDR_W      = 32;
    localparam int BLOCK_BYTES = 64;
    localparam int WORD_BYTES  = 4;
    localparam int BEATS       = BLOCK_BYTES / WORD_BYTES;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_priv = '0;
    logic              req_virt = 1'b0;
    logic [2:0]        menv_en = '0, henv_en = '0, senv_en = '0;
    logic              probe_rd_ok = 1'b0, probe_wr_ok = 1'b0;
    logic              mem_wvalid;
    logic              mem_wready = 1'b0;
    logic [ADDR_W-1:0] mem_waddr;
    logic [8*WORD_BYTES-1:0] mem_wdata;
    logic              mem_fault = 1'b0;
    logic              done, exc_valid;
    logic [4:0]        exc_cause;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cbo_engine #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .WORD_BYTES(WORD_BYTES)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_priv(req_priv), .req_virt(req_virt),
        .menv_en(menv_en), .henv_en(henv_en), .senv_en(senv_en),
        .probe_rd_ok(probe_rd_ok), .probe_wr_ok(probe_wr_ok),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .mem_fault(mem_fault),
        .done(done), .exc_valid(exc_valid), .exc_cause(exc_cause)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference outcome: 0 success, otherwise the cause code.
    function automatic int model(input int op, input int priv, input bit virt,
                                 input bit [2:0] m, input bit [2:0] h, input bit [2:0] s,
                                 input bit rd, input bit wr);
        if (op == 3) return 2;                                    // R1
        if (priv != 3 && !m[op]) return 2;                        // R2
        if (virt && ((priv <= 1 && !h[op]) || (priv == 0 && !s[op]))) return 22; // R3
        if (priv == 0 && !s[op]) return 2;                        // R4
        if (op != 0 && !(rd || wr)) return 7;                     // R10
        return 0;
    endfunction

    task automatic run_req(input int op, input logic [ADDR_W-1:0] addr, input int priv,
                           input bit virt, input bit [2:0] m, input bit [2:0] h,
                           input bit [2:0] s, input bit rd, input bit wr,
                           input int ready_pct, input int fault_beat);
        int exp;
        logic [ADDR_W-1:0] base;
        exp  = model(op, priv, virt, m, h, s, rd, wr);
        base = addr & ~ADDR_W'(BLOCK_BYTES - 1);
        req_valid = 1'b1; req_op = 2'(op); req_addr = addr; req_priv = 2'(priv);
        req_virt = virt; menv_en = m; henv_en = h; senv_en = s;
        probe_rd_ok = rd; probe_wr_ok = wr;
        chk(req_ready == 1'b1, "R11 ready when idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (exp != 0) begin
            chk(exc_valid == 1'b1 && exc_cause == 5'(exp), "R2/R3/R4/R10 cause", exc_cause, exp);
            chk(done == 1'b0 && mem_wvalid == 1'b0, "R11 no done or write on exception", {done, mem_wvalid}, 0);
        end else if (op != 0) begin
            chk(done == 1'b1 && exc_valid == 1'b0, "R10 maintenance done", {done, exc_valid}, 2);
            chk(mem_wvalid == 1'b0, "R10 no write", mem_wvalid, 0);
        end else begin
            for (int b = 0, guard = 0; ; guard++) begin
                bit rdy, flt;
                logic [ADDR_W-1:0] held;
                if (guard > 2000) begin
                    chk(1'b0, "R8 zero never finished", b, BEATS);
                    break;
                end
                chk(mem_wvalid == 1'b1 && mem_waddr == base + ADDR_W'(b * WORD_BYTES),
                    "R6 beat address", mem_waddr, base + ADDR_W'(b * WORD_BYTES));
                chk(mem_wdata == '0, "R6 zero data", mem_wdata, 0);
                chk(req_ready == 1'b0 && done == 1'b0, "R11 busy while writing", {req_ready, done}, 0);
                held = mem_waddr;
                rdy  = ($urandom % 100) < ready_pct;
                flt  = rdy && (b == fault_beat);
                mem_wready = rdy; mem_fault = flt;
                @(negedge clk);
                mem_wready = 1'b0; mem_fault = 1'b0;
                if (!rdy) begin
                    chk(mem_wvalid == 1'b1 && mem_waddr == held, "R7 stall hold", mem_waddr, held);
                end else if (flt) begin
                    chk(exc_valid == 1'b1 && exc_cause == 5'd7, "R9 store fault", exc_cause, 7);
                    chk(mem_wvalid == 1'b0 && done == 1'b0, "R9 abort stops writes", {mem_wvalid, done}, 0);
                    break;
                end else if (b == BEATS - 1) begin
                    chk(done == 1'b1 && exc_valid == 1'b0, "R8 done after last", {done, exc_valid}, 2);
                    chk(mem_wvalid == 1'b0, "R8 no extra writes", mem_wvalid, 0);
                    break;
                end else begin
                    b++;
                end
            end
        end
        @(negedge clk);
        chk(done == 1'b0 && exc_valid == 1'b0, "R11 single cycle pulse", {done, exc_valid}, 0);
        chk(exc_cause == 5'd0, "R11 cause idle zero", exc_cause, 0);
    endtask

    initial begin : watchdog
        for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12
        chk(req_ready == 1'b1 && mem_wvalid == 1'b0 && done == 1'b0 && exc_valid == 1'b0,
            "R12 reset state", {req_ready, mem_wvalid, done, exc_valid}, 8);
        rst = 1'b0;
        @(negedge clk);

        // R5: machine privilege with every enable clear still zeroes
        run_req(0, 32'h0000_1234, 3, 1'b1, 3'b000, 3'b000, 3'b000, 1'b0, 1'b0, 100, -1);
        // R2: machine tier beats the virtual tier
        run_req(1, 32'h10, 1, 1'b1, 3'b101, 3'b000, 3'b000, 1'b1, 1'b1, 100, -1);
        // R3: user, virtualized, hypervisor ok, supervisor clear
        run_req(2, 32'h20, 0, 1'b1, 3'b111, 3'b111, 3'b011, 1'b1, 1'b1, 100, -1);
        // R4: user, not virtualized, supervisor clear
        run_req(0, 32'h30, 0, 1'b0, 3'b111, 3'b000, 3'b110, 1'b1, 1'b1, 100, -1);
        // R1: reserved kind
        run_req(3, 32'h40, 3, 1'b0, 3'b111, 3'b111, 3'b111, 1'b1, 1'b1, 100, -1);
        // R10: writable only, then neither
        run_req(1, 32'h50, 1, 1'b0, 3'b111, 3'b111, 3'b111, 1'b0, 1'b1, 100, -1);
        run_req(2, 32'h60, 1, 1'b0, 3'b111, 3'b111, 3'b111, 1'b0, 1'b0, 100, -1);
        // R6: already aligned, and all low bits set
        run_req(0, 32'h0000_8000, 1, 1'b0, 3'b111, 3'b111, 3'b111, 1'b0, 1'b0, 60, -1);
        run_req(0, 32'hFFFF_FFFF, 0, 1'b1, 3'b111, 3'b111, 3'b111, 1'b0, 1'b0, 60, -1);
        // R9: fault on first and on last beat
        run_req(0, 32'h0000_0100, 3, 1'b0, 3'b111, 3'b111, 3'b111, 1'b0, 1'b0, 100, 0);
        run_req(0, 32'h0000_0200, 3, 1'b0, 3'b111, 3'b111, 3'b111, 1'b0, 1'b0, 100, BEATS - 1);

        for (int i = 0; i < 300; i++) begin
            int op, pr, fb;
            bit [2:0] m, h, s;
            op = (($urandom % 10) == 0) ? 3 : int'($urandom % 3);
            case ($urandom % 3)
                0: pr = 0;
                1: pr = 1;
                default: pr = 3;
            endcase
            m = 3'($urandom | $urandom);
            h = 3'($urandom | $urandom);
            s = 3'($urandom | $urandom);
            fb = (($urandom % 5) == 0) ? int'($urandom % BEATS) : -1;
            run_req(op, $urandom, pr, 1'($urandom), m, h, s, 1'($urandom), 1'($urandom),
                    40 + int'($urandom % 61), fb);
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule